// File: doc/BRIEF.md
# Trapped Instruction Transformer

When a load, store or atomic access traps, the trap handler benefits from a normalised copy of the faulting instruction. This block takes the raw encoding of that instruction, together with the current register width (32 or 64 bits), and produces the 32-bit value to be written into the trap-instruction CSR. Compressed memory accesses from quadrants 0 and 2 are rewritten as their full 32-bit counterparts, and bit 1 is cleared so software can tell that the original was 16 bits wide. Full-width memory instructions are passed through.

In every memory form the rs1 position (bits 19:15) is reused as an address-offset field, and this block always drives it to zero. Compressed instructions that are not memory accesses, quadrant 1, and 128-bit-only forms all yield zero. The result is registered: a request presented with `in_valid` appears on `out_tinst` one cycle later, with `out_valid` raised for exactly that cycle.

Top module: `trap_insn_xform`

## Requirements
- R1: An instruction whose bits [1:0] differ from 2'b11 is compressed; its quadrant is bits [1:0], its function is bits [15:13], and only bits [15:0] affect the result.
- R2: Quadrant 1, quadrant 0 functions 0 and 4, and quadrant 2 functions 0 and 4 produce an all-zero result.
- R3: Quadrant 0 function 2 expands to LW (opcode 0000011, funct3 2) and function 6 to SW (opcode 0100011, funct3 2); the register fields at [9:7] and [4:2] name register 8 plus the field, offset bits [5:3] come from [12:10], bit 2 from [6] and bit 6 from [5].
- R4: Quadrant 0 function 3 expands to FLW (opcode 0000111, funct3 2) and function 7 to FSW (opcode 0100111, funct3 2) when `in_xlen64` is 0; when it is 1 they expand to LD and SD (funct3 3) with the double offset of R5.
- R5: Quadrant 0 functions 1 and 5 expand to FLD and FSD (funct3 3); the offset takes bits [5:3] from [12:10] and bits [7:6] from [6:5]. Load offsets occupy bits 31:20; store offsets are split into bits 31:25 (offset 11:5) and 11:7 (offset 4:0).
- R6: Quadrant 2 functions 1, 2, 3, 5, 6, 7 expand to the same instruction kinds as the matching quadrant 0 functions, with the base register being the stack pointer and rd (bits [11:7]) or rs2 (bits [6:2]) taken at full 5-bit width.
- R7: Every compressed expansion has bit 1 cleared and bits 19:15 equal to zero.
- R8: A 32-bit instruction with major opcode LOAD, STORE, AMO (0101111), FP-LOAD or FP-STORE, or SYSTEM (1110011) with funct3 4, passes through with bits 19:15 forced to zero.
- R9: Any other 32-bit instruction passes through unchanged.
- R10: After reset `out_valid` is 0 and `out_tinst` is zero; each cycle with `in_valid` high loads a new result, `out_valid` follows `in_valid` by one cycle, and `out_tinst` holds while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe for `in_insn` |
| in_insn | input | 32 | Raw encoding of the trapping instruction |
| in_xlen64 | input | 1 | 1 when the hart runs with 64-bit registers, 0 for 32 |
| out_valid | output | 1 | Result on `out_tinst` is new this cycle |
| out_tinst | output | 32 | Transformed instruction value |

## Verification
The clocked properties take `in_insn` and `in_xlen64` as meaningful only in cycles where `in_valid` is high, and assume `in_valid` is low while reset is asserted. The stimulus drives every request for exactly one or two consecutive cycles on the falling edge, keeps `in_valid` low throughout reset, and changes `in_insn` during idle cycles only to confirm that it is ignored. Compressed encodings are assembled in the bench from register and offset values, so the expected 32-bit forms come from the field placement rules rather than from bit slicing of the input.

// File: rtl/tix_pkg.sv
package tix_pkg;

   localparam int unsigned INSN_W  = 32;
   localparam int unsigned CINSN_W = 16;
   localparam int unsigned REG_W   = 5;
   localparam int unsigned IMM_W   = 12;

   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_FLOAD  = 7'b0000111;
   localparam logic [6:0] OPC_FSTORE = 7'b0100111;
   localparam logic [6:0] OPC_AMO    = 7'b0101111;
   localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

   localparam logic [2:0] F3_WORD = 3'd2;
   localparam logic [2:0] F3_DBL  = 3'd3;
   localparam logic [2:0] F3_HYP  = 3'd4;

   typedef enum logic [1:0] {
      XK_NONE  = 2'd0,
      XK_LOAD  = 2'd1,
      XK_STORE = 2'd2
   } xfer_kind_e;

   typedef struct packed {
      xfer_kind_e        kind;
      logic              fp;
      logic              dbl;
      logic [REG_W-1:0]  reg_id;
      logic [IMM_W-1:0]  imm;
   } xfer_desc_t;

endpackage

// File: rtl/tix_cexpand.sv
module tix_cexpand
   import tix_pkg::*;
#(
   parameter int unsigned CW = CINSN_W,
   parameter int unsigned W  = INSN_W
) (
   input  logic [CW-1:0] cins,
   input  logic          xlen64,
   output logic [W-1:0]  expanded
);

   localparam int unsigned FN_LO = CW - 3;

   generate
      if (CW != 16) begin : g_bad_cw
         $error("tix_cexpand: compressed width must be 16");
      end
      if (W != 32) begin : g_bad_w
         $error("tix_cexpand: expanded width must be 32");
      end
   endgenerate

   logic [1:0]       quad;
   logic [2:0]       fsel;
   logic [REG_W-1:0] reg_short;
   logic [REG_W-1:0] reg_rd;
   logic [REG_W-1:0] reg_rs2;
   logic [IMM_W-1:0] off_w, off_d, off_lwsp, off_ldsp, off_swsp, off_sdsp;
   xfer_desc_t       d;
   logic [6:0]       opc;
   logic [2:0]       f3;
   logic [W-1:0]     raw;

   assign quad      = cins[1:0];
   assign fsel      = cins[CW-1:FN_LO];
   assign reg_short = {2'b01, cins[4:2]};
   assign reg_rd    = cins[11:7];
   assign reg_rs2   = cins[6:2];

   // offset layouts, one per compressed format
   assign off_w    = {5'd0, cins[5], cins[12:10], cins[6], 2'b00};
   assign off_d    = {4'd0, cins[6:5], cins[12:10], 3'b000};
   assign off_lwsp = {4'd0, cins[3:2], cins[12], cins[6:4], 2'b00};
   assign off_ldsp = {3'd0, cins[4:2], cins[12], cins[6:5], 3'b000};
   assign off_swsp = {4'd0, cins[8:7], cins[12:9], 2'b00};
   assign off_sdsp = {3'd0, cins[9:7], cins[12:10], 3'b000};

   always_comb begin
      d = '{kind: XK_NONE, fp: 1'b0, dbl: 1'b0, reg_id: '0, imm: '0};
      unique case (quad)
         2'b00: begin
            d.reg_id = reg_short;
            unique case (fsel)
               3'd1: begin d.kind = XK_LOAD;  d.fp = 1'b1; d.dbl = 1'b1; d.imm = off_d; end
               3'd2: begin d.kind = XK_LOAD;  d.imm = off_w; end
               3'd3: begin
                  d.kind = XK_LOAD;
                  if (xlen64) begin d.dbl = 1'b1; d.imm = off_d; end
                  else        begin d.fp  = 1'b1; d.imm = off_w; end
               end
               3'd5: begin d.kind = XK_STORE; d.fp = 1'b1; d.dbl = 1'b1; d.imm = off_d; end
               3'd6: begin d.kind = XK_STORE; d.imm = off_w; end
               3'd7: begin
                  d.kind = XK_STORE;
                  if (xlen64) begin d.dbl = 1'b1; d.imm = off_d; end
                  else        begin d.fp  = 1'b1; d.imm = off_w; end
               end
               default: d.kind = XK_NONE;
            endcase
         end
         2'b10: begin
            unique case (fsel)
               3'd1: begin d.kind = XK_LOAD; d.reg_id = reg_rd; d.fp = 1'b1; d.dbl = 1'b1; d.imm = off_ldsp; end
               3'd2: begin d.kind = XK_LOAD; d.reg_id = reg_rd; d.imm = off_lwsp; end
               3'd3: begin
                  d.kind = XK_LOAD; d.reg_id = reg_rd;
                  if (xlen64) begin d.dbl = 1'b1; d.imm = off_ldsp; end
                  else        begin d.fp  = 1'b1; d.imm = off_lwsp; end
               end
               3'd5: begin d.kind = XK_STORE; d.reg_id = reg_rs2; d.fp = 1'b1; d.dbl = 1'b1; d.imm = off_sdsp; end
               3'd6: begin d.kind = XK_STORE; d.reg_id = reg_rs2; d.imm = off_swsp; end
               3'd7: begin
                  d.kind = XK_STORE; d.reg_id = reg_rs2;
                  if (xlen64) begin d.dbl = 1'b1; d.imm = off_sdsp; end
                  else        begin d.fp  = 1'b1; d.imm = off_swsp; end
               end
               default: d.kind = XK_NONE;
            endcase
         end
         default: d.kind = XK_NONE;
      endcase
   end

   always_comb begin
      f3 = d.dbl ? F3_DBL : F3_WORD;
      if (d.kind == XK_STORE) opc = d.fp ? OPC_FSTORE : OPC_STORE;
      else                    opc = d.fp ? OPC_FLOAD  : OPC_LOAD;
      unique case (d.kind)
         XK_LOAD:  raw = {d.imm, {REG_W{1'b0}}, f3, d.reg_id, opc};
         XK_STORE: raw = {d.imm[11:5], d.reg_id, {REG_W{1'b0}}, f3, d.imm[4:0], opc};
         default:  raw = '0;
      endcase
      // bit 1 low marks a 16-bit origin
      expanded = raw & ~W'(2);
   end

endmodule

// File: rtl/tix_wide_pass.sv
module tix_wide_pass
   import tix_pkg::*;
#(
   parameter int unsigned W = INSN_W
) (
   input  logic [W-1:0] ins,
   output logic [W-1:0] passed
);

   localparam int unsigned RS1_LO = 15;
   localparam int unsigned RS1_HI = RS1_LO + REG_W - 1;

   generate
      if (W != 32) begin : g_bad_w
         $error("tix_wide_pass: width must be 32");
      end
   endgenerate

   logic [6:0] major;
   logic [2:0] f3;
   logic       has_off;

   assign major = ins[6:0];
   assign f3    = ins[14:12];

   always_comb begin
      unique case (major)
         OPC_LOAD, OPC_STORE, OPC_AMO, OPC_FLOAD, OPC_FSTORE: has_off = 1'b1;
         OPC_SYSTEM: has_off = (f3 == F3_HYP);
         default:    has_off = 1'b0;
      endcase
   end

   always_comb begin
      passed = ins;
      if (has_off) passed[RS1_HI:RS1_LO] = '0;
   end

endmodule

// File: rtl/trap_insn_xform.sv
module trap_insn_xform
   import tix_pkg::*;
#(
   parameter int unsigned W  = INSN_W,
   parameter int unsigned CW = CINSN_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [31:0]  in_insn,
   input  logic         in_xlen64,
   output logic         out_valid,
   output logic [31:0]  out_tinst
);

   generate
      if (W != 32 || CW != 16) begin : g_bad_cfg
         $error("trap_insn_xform: only 32/16-bit encodings are supported");
      end
   endgenerate

   logic          is_comp;
   logic [W-1:0]  c_val;
   logic [W-1:0]  w_val;
   logic [W-1:0]  nxt;
   logic          vld_q;
   logic [W-1:0]  val_q;

   assign is_comp = (in_insn[1:0] != 2'b11);

   tix_cexpand #(.CW(CW), .W(W)) u_cexp (
      .cins     (in_insn[CW-1:0]),
      .xlen64   (in_xlen64),
      .expanded (c_val)
   );

   tix_wide_pass #(.W(W)) u_wide (
      .ins    (in_insn),
      .passed (w_val)
   );

   assign nxt = is_comp ? c_val : w_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         val_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) val_q <= nxt;
      end
   end

   assign out_valid = vld_q;
   assign out_tinst = val_q;

   // R10: one-cycle valid pipeline and hold
   p_vld_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_vld_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_tinst));

   // R2: quadrant 1 yields zero
   p_q1_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_insn[1:0] == 2'b01) |=> (out_tinst == '0));

   // R7: compressed results have bit 1 and the offset field clear
   p_cbit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_insn[1:0] != 2'b11) |=> (out_tinst[1] == 1'b0 && out_tinst[19:15] == '0));

   // R8: full-width loads lose their base register field
   p_wide_ld_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_insn[6:0] == OPC_LOAD) |=>
         (out_tinst[19:15] == '0 && out_tinst[31:20] == $past(in_insn[31:20])));

   // R9: register-register ALU ops pass untouched
   p_wide_alu_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_insn[6:0] == 7'b0110011) |=> (out_tinst == $past(in_insn)));

endmodule

// File: tb/sim_trap_insn_xform.sv
module sim_trap_insn_xform;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_insn = '0;
   logic        in_xlen64 = 1'b0;
   logic        out_valid;
   logic [31:0] out_tinst;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   trap_insn_xform u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
      .in_xlen64(in_xlen64), .out_valid(out_valid), .out_tinst(out_tinst)
   );

   localparam logic [6:0] LDC  = 7'b0000001; // LOAD with bit1 cleared
   localparam logic [6:0] FLDC = 7'b0000101;
   localparam logic [6:0] STC  = 7'b0100001;
   localparam logic [6:0] FSTC = 7'b0100101;

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
      end
   endtask

   // present one request, return the registered result
   task automatic apply(input logic [31:0] ins, input logic x64, output logic [31:0] res);
      @(negedge clk);
      in_insn = ins; in_xlen64 = x64; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R10 valid", {31'd0, out_valid}, 32'd1);
      res = out_tinst;
   endtask

   function automatic logic [31:0] exp_ld(input logic [11:0] off, input logic [4:0] rd,
                                          input logic [2:0] f3, input logic [6:0] opc);
      return {off, 5'd0, f3, rd, opc};
   endfunction

   function automatic logic [31:0] exp_st(input logic [11:0] off, input logic [4:0] rs2,
                                          input logic [2:0] f3, input logic [6:0] opc);
      return {off[11:5], rs2, 5'd0, f3, off[4:0], opc};
   endfunction

   // quadrant 0 encoders (word and double offsets)
   function automatic logic [15:0] enc_q0w(input logic [2:0] fn, input logic [2:0] bp,
                                           input logic [2:0] rp, input logic [6:0] off);
      return {fn, off[5:3], bp, off[2], off[6], rp, 2'b00};
   endfunction
   function automatic logic [15:0] enc_q0d(input logic [2:0] fn, input logic [2:0] bp,
                                           input logic [2:0] rp, input logic [7:0] off);
      return {fn, off[5:3], bp, off[7:6], rp, 2'b00};
   endfunction
   // quadrant 2 encoders
   function automatic logic [15:0] enc_lwsp(input logic [2:0] fn, input logic [4:0] rd, input logic [7:0] off);
      return {fn, off[5], rd, off[4:2], off[7:6], 2'b10};
   endfunction
   function automatic logic [15:0] enc_ldsp(input logic [2:0] fn, input logic [4:0] rd, input logic [8:0] off);
      return {fn, off[5], rd, off[4:3], off[8:6], 2'b10};
   endfunction
   function automatic logic [15:0] enc_swsp(input logic [2:0] fn, input logic [4:0] rs, input logic [7:0] off);
      return {fn, off[5:2], off[7:6], rs, 2'b10};
   endfunction
   function automatic logic [15:0] enc_sdsp(input logic [2:0] fn, input logic [4:0] rs, input logic [8:0] off);
      return {fn, off[5:3], off[8:6], rs, 2'b10};
   endfunction

   task automatic t_reset();
      @(negedge clk);
      check("R10 reset valid", {31'd0, out_valid}, 32'd0);
      check("R10 reset value", out_tinst, 32'd0);
   endtask

   task automatic t_quad0_word();
      logic [31:0] r;
      apply({16'h0000, enc_q0w(3'd2, 3'd2, 3'd5, 7'h4c)}, 1'b0, r);
      check("R3 c.lw", r, exp_ld(12'h04c, 5'd13, 3'd2, LDC));
      apply({16'h0000, enc_q0w(3'd6, 3'd7, 3'd1, 7'h7c)}, 1'b1, r);
      check("R3 c.sw", r, exp_st(12'h07c, 5'd9, 3'd2, STC));
      // R1: upper half ignored for compressed input
      apply({16'hBEEF, enc_q0w(3'd2, 3'd0, 3'd0, 7'h04)}, 1'b0, r);
      check("R1 upper ignored", r, exp_ld(12'h004, 5'd8, 3'd2, LDC));
   endtask

   task automatic t_quad0_xlen();
      logic [31:0] r;
      apply({16'h0, enc_q0w(3'd3, 3'd1, 3'd4, 7'h28)}, 1'b0, r);
      check("R4 c.flw xlen32", r, exp_ld(12'h028, 5'd12, 3'd2, FLDC));
      apply({16'h0, enc_q0d(3'd3, 3'd1, 3'd4, 8'hd8)}, 1'b1, r);
      check("R4 c.ld xlen64", r, exp_ld(12'h0d8, 5'd12, 3'd3, LDC));
      apply({16'h0, enc_q0w(3'd7, 3'd6, 3'd3, 7'h44)}, 1'b0, r);
      check("R4 c.fsw xlen32", r, exp_st(12'h044, 5'd11, 3'd2, FSTC));
      apply({16'h0, enc_q0d(3'd7, 3'd6, 3'd3, 8'hf8)}, 1'b1, r);
      check("R4 c.sd xlen64", r, exp_st(12'h0f8, 5'd11, 3'd3, STC));
   endtask

   task automatic t_quad0_double();
      logic [31:0] r;
      apply({16'h0, enc_q0d(3'd1, 3'd3, 3'd6, 8'h68)}, 1'b0, r);
      check("R5 c.fld", r, exp_ld(12'h068, 5'd14, 3'd3, FLDC));
      apply({16'h0, enc_q0d(3'd5, 3'd2, 3'd7, 8'hb0)}, 1'b1, r);
      check("R5 c.fsd", r, exp_st(12'h0b0, 5'd15, 3'd3, FSTC));
   endtask

   task automatic t_quad2_sp();
      logic [31:0] r;
      apply({16'h0, enc_lwsp(3'd2, 5'd17, 8'hec)}, 1'b0, r);
      check("R6 c.lwsp", r, exp_ld(12'h0ec, 5'd17, 3'd2, LDC));
      apply({16'h0, enc_ldsp(3'd3, 5'd31, 9'h1f8)}, 1'b1, r);
      check("R6 c.ldsp", r, exp_ld(12'h1f8, 5'd31, 3'd3, LDC));
      apply({16'h0, enc_lwsp(3'd3, 5'd6, 8'h94)}, 1'b0, r);
      check("R6 c.flwsp", r, exp_ld(12'h094, 5'd6, 3'd2, FLDC));
      apply({16'h0, enc_ldsp(3'd1, 5'd20, 9'h148)}, 1'b0, r);
      check("R6 c.fldsp", r, exp_ld(12'h148, 5'd20, 3'd3, FLDC));
      apply({16'h0, enc_swsp(3'd6, 5'd1, 8'hb4)}, 1'b0, r);
      check("R6 c.swsp", r, exp_st(12'h0b4, 5'd1, 3'd2, STC));
      apply({16'h0, enc_sdsp(3'd7, 5'd27, 9'h0e8)}, 1'b1, r);
      check("R6 c.sdsp", r, exp_st(12'h0e8, 5'd27, 3'd3, STC));
      apply({16'h0, enc_swsp(3'd7, 5'd3, 8'h7c)}, 1'b0, r);
      check("R6 c.fswsp", r, exp_st(12'h07c, 5'd3, 3'd2, FSTC));
      apply({16'h0, enc_sdsp(3'd5, 5'd19, 9'h1c0)}, 1'b1, r);
      check("R6 c.fsdsp", r, exp_st(12'h1c0, 5'd19, 3'd3, FSTC));
      check("R7 bit1 and offset field", {30'd0, r[1], |r[19:15]}, 32'd0);
   endtask

   task automatic t_nonmem_zero();
      logic [31:0] r;
      apply(32'h0000_0405, 1'b0, r);           // quadrant 1
      check("R2 quadrant1", r, 32'd0);
      apply(32'h0000_1041, 1'b1, r);           // quadrant 1, other function
      check("R2 quadrant1 b", r, 32'd0);
      apply(32'h0000_0048, 1'b0, r);           // q0 function 0
      check("R2 q0 fn0", r, 32'd0);
      apply(32'h0000_8000 | 32'h0000_0010, 1'b0, r); // q0 function 4
      check("R2 q0 fn4", r, 32'd0);
      apply(32'h0000_0586, 1'b1, r);           // q2 function 0
      check("R2 q2 fn0", r, 32'd0);
      apply(32'h0000_9002 | 32'h0000_0080, 1'b0, r); // q2 function 4
      check("R2 q2 fn4", r, 32'd0);
   endtask

   task automatic t_wide();
      logic [31:0] r;
      apply({12'd8, 5'd10, 3'd2, 5'd5, 7'b0000011}, 1'b0, r);
      check("R8 lw", r, {12'd8, 5'd0, 3'd2, 5'd5, 7'b0000011});
      apply({7'h12, 5'd6, 5'd30, 3'd3, 5'd4, 7'b0100011}, 1'b1, r);
      check("R8 sd", r, {7'h12, 5'd6, 5'd0, 3'd3, 5'd4, 7'b0100011});
      apply({5'b00001, 2'b00, 5'd3, 5'd12, 3'd2, 5'd4, 7'b0101111}, 1'b0, r);
      check("R8 amo", r, {5'b00001, 2'b00, 5'd3, 5'd0, 3'd2, 5'd4, 7'b0101111});
      apply({12'h7f0, 5'd9, 3'd3, 5'd2, 7'b0000111}, 1'b0, r);
      check("R8 fld", r, {12'h7f0, 5'd0, 3'd3, 5'd2, 7'b0000111});
      apply({7'h01, 5'd8, 5'd21, 3'd2, 5'd16, 7'b0100111}, 1'b0, r);
      check("R8 fsw", r, {7'h01, 5'd8, 5'd0, 3'd2, 5'd16, 7'b0100111});
      apply({7'h30, 5'd0, 5'd7, 3'd4, 5'd9, 7'b1110011}, 1'b1, r);
      check("R8 hyp load", r, {7'h30, 5'd0, 5'd0, 3'd4, 5'd9, 7'b1110011});
      apply({12'h300, 5'd7, 3'd1, 5'd9, 7'b1110011}, 1'b1, r);
      check("R9 csrrw", r, {12'h300, 5'd7, 3'd1, 5'd9, 7'b1110011});
      apply({7'h20, 5'd3, 5'd14, 3'd0, 5'd1, 7'b0110011}, 1'b0, r);
      check("R9 sub", r, {7'h20, 5'd3, 5'd14, 3'd0, 5'd1, 7'b0110011});
      apply({12'h123, 5'd22, 3'd0, 5'd2, 7'b0010011}, 1'b0, r);
      check("R9 addi", r, {12'h123, 5'd22, 3'd0, 5'd2, 7'b0010011});
   endtask

   task automatic t_latency_hold();
      logic [31:0] a, b;
      a = {12'd16, 5'd11, 3'd2, 5'd6, 7'b0000011};
      b = {7'h00, 5'd5, 5'd2, 3'd0, 5'd7, 7'b0110011};
      @(negedge clk);
      in_insn = a; in_xlen64 = 1'b0; in_valid = 1'b1;
      @(negedge clk);
      check("R10 back2back first", out_tinst, {12'd16, 5'd0, 3'd2, 5'd6, 7'b0000011});
      in_insn = b;
      @(negedge clk);
      in_valid = 1'b0;
      check("R10 back2back second", out_tinst, b);
      in_insn = 32'hFFFF_FFFF;
      @(negedge clk);
      check("R10 valid drops", {31'd0, out_valid}, 32'd0);
      in_insn = 32'h0000_4000;
      @(negedge clk);
      @(negedge clk);
      check("R10 hold while idle", out_tinst, b);
      check("R10 valid stays low", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_quad0_word();
      t_quad0_xlen();
      t_quad0_double();
      t_quad2_sp();
      t_nonmem_zero();
      t_wide();
      t_latency_hold();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      #1000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

endmodule